// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block sends and receives single characters over one open-drain smart-card I/O line. Every character carries a start bit, eight data bits sent least significant bit first, and a parity bit. The length of one bit, the elementary time unit (ETU), is a whole number of base clock cycles. A two-bit select picks that number. Parity is always generated and always checked, and one control input picks its sense.

Outbound bytes enter through a valid/ready stream. A byte is accepted only in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while a character is being sent or received on the line, so the source must hold `tx_valid` and `tx_data` until it is accepted. Inbound bytes leave through a valid/ready stream. `rx_valid` stays high with `rx_data` and `rx_perr` until a cycle with `rx_ready` high. If a newer character completes before the sink accepts the held one, the held byte is replaced by the newer one.

In the normal protocol each side can flag a bad character. The receiver pulls the line low during the guard time after a parity failure. The transmitter looks for that pulse and sends the character once more. A block-transfer input turns this error exchange off in both directions. A GSM input moves the transmit-end flag to an earlier point in the character.

Top module: `sc_char_xcvr`

## Requirements
- R1: `etu_sel` sets the ETU length in base clock cycles: 0 selects 32, 1 selects 64, 2 selects 372 and 3 selects 256.
- R2: A transmitted character drives the line low for a 0 and releases it for a 1. Bits are sent in this order: a low start bit, data bits 0 to 7, then parity. The number of ones in data and parity together is even when `odd_parity` is 0 and odd when it is 1.
- R3: `tx_end` goes low in the cycle after a byte is accepted. Counted from the accept edge, it rises after 22·(ETU/2)+1 cycles with `gsm_mode` 1 and after 25·(ETU/2)+1 cycles with `gsm_mode` 0.
- R4: With `block_mode` 0, a low line seen 11 ETU into a transmitted character sets `tx_err` and resends the character once. The resent character starts one cycle after 13 ETU. With `block_mode` 1 the line is not examined: `tx_err` stays 0 and the character is sent once.
- R5: The receiver samples each bit at the middle of its ETU, counted from the detected falling edge of the start bit. It presents the eight data bits on `rx_data` with `rx_valid` high, and sets `rx_perr` to 1 when the parity check fails.
- R6: After a parity failure with `block_mode` 0, the receiver pulls the line low for exactly one ETU, starting 10.5 ETU after the start edge. With `block_mode` 1 it never pulls the line low.
- R7: `rx_valid` holds until a cycle with `rx_ready` high, and drops in the cycle after that. A character that completes while `rx_valid` is high replaces the held byte.
- R8: `tx_ready` is low while a character is being sent or received. After an accept, the start bit appears on the line in the next cycle.
- R9: During reset `io_drive_low`, `rx_valid`, `tx_end` and `tx_err` are 0, and `tx_ready` is 1.
- R10: The line is released while idle, and the transmitter and receiver never pull it low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| etu_sel | input | 2 | Clock cycles per ETU select |
| odd_parity | input | 1 | 0 even, 1 odd parity |
| gsm_mode | input | 1 | Early transmit-end point |
| block_mode | input | 1 | Disables error signalling and retransmission |
| tx_valid | input | 1 | Outbound byte offered |
| tx_ready | output | 1 | Outbound byte can be taken |
| tx_data | input | 8 | Outbound byte |
| rx_valid | output | 1 | Inbound byte held |
| rx_ready | input | 1 | Sink takes the inbound byte |
| rx_data | output | 8 | Inbound byte |
| rx_perr | output | 1 | Inbound byte failed parity |
| tx_end | output | 1 | Transmit-end flag |
| tx_err | output | 1 | Card flagged an error on this byte |
| io_line | input | 1 | Line level read back |
| io_drive_low | output | 1 | Pull the line low |

## Verification
A wrong ETU count or a wrong half-unit position shows first as a shifted `tx_end` edge, so the bench measures that edge to the exact cycle for every select and for both GSM settings. A corrupt frame register, or a wrong parity sense, shows at the model card's mid-bit samples within that same character. A wrong receiver shift or sample point shows in `rx_data` as soon as one character completes. A stuck error state shows as a low count on the line in the guard window that is not exactly one ETU, or as a wrong number of characters seen by the card.

// File: rtl/sc_xcvr_pkg.sv
package sc_xcvr_pkg;
  // parity bit that makes the count of ones even (odd_sel 0) or odd (odd_sel 1)
  function automatic logic par_of(logic [15:0] v, logic odd_sel);
    return (^v) ^ odd_sel;
  endfunction
endpackage

// File: rtl/sc_half_etu_ctr.sv
module sc_half_etu_ctr #(
  parameter int CNT_W = 8,
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] half_cnt,
  output logic [POS_W-1:0] pos,
  output logic             fresh
);
  logic [CNT_W-1:0] cnt;

  assign fresh = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pos <= '0;
    end else if (clr) begin
      cnt <= '0;
      pos <= '0;
    end else if (run) begin
      if (cnt == half_cnt - CNT_W'(1)) begin
        cnt <= '0;
        pos <= pos + POS_W'(1);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R1: the count inside a half unit never passes the selected length
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half_cnt));
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              odd_par,
  input  logic              gsm,
  input  logic              blk,
  input  logic              line_in,
  input  logic              rx_busy,
  input  logic [POS_W-1:0]  pos,
  input  logic              fresh,
  output logic              ctr_clr,
  output logic              ctr_run,
  output logic              drive_low,
  output logic              busy,
  output logic              tx_end,
  output logic              tx_err
);
  localparam int FRAME_W = DATA_W + 2;
  localparam logic [POS_W-1:0] P_REL = POS_W'(2 * FRAME_W);
  localparam logic [POS_W-1:0] P_CHK = POS_W'(2 * FRAME_W + 2);
  localparam logic [POS_W-1:0] P_END = POS_W'(2 * FRAME_W + 5);
  localparam logic [POS_W-1:0] P_PER = POS_W'(2 * FRAME_W + 6);

  logic               active, retried, again;
  logic [FRAME_W-1:0] frame, frame_sh;
  logic [POS_W-2:0]   idx;
  logic               accept, tick, card_err, will_retry;

  assign in_ready   = !active && !rx_busy;
  assign accept     = in_valid && in_ready;
  assign tick       = active && fresh;
  assign card_err   = !blk && !line_in;
  assign will_retry = card_err && !retried;
  assign idx        = pos[POS_W-1:1];
  assign frame_sh   = frame >> idx;
  assign drive_low  = active && (pos < P_REL) && !frame_sh[0];
  assign ctr_clr    = accept || (tick && (pos == P_PER) && again);
  assign ctr_run    = active;
  assign busy       = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      retried <= 1'b0;
      again   <= 1'b0;
      frame   <= '1;
      tx_end  <= 1'b0;
      tx_err  <= 1'b0;
    end else if (accept) begin
      active  <= 1'b1;
      retried <= 1'b0;
      again   <= 1'b0;
      frame   <= {par_of(16'(in_data), odd_par), in_data, 1'b0};
      tx_end  <= 1'b0;
      tx_err  <= 1'b0;
    end else if (tick) begin
      if (pos == P_CHK) begin
        if (card_err) tx_err <= 1'b1;
        if (will_retry) again <= 1'b1;
        if (gsm && !will_retry) tx_end <= 1'b1;
      end
      if ((pos == P_END) && !gsm && !again) tx_end <= 1'b1;
      if (pos == P_PER) begin
        if (again) begin
          again   <= 1'b0;
          retried <= 1'b1;
        end else begin
          active <= 1'b0;
        end
      end
    end
  end

  // R8: an accepted byte puts the start bit out at once and closes the input
  assert_start_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (drive_low && !in_ready));
  // R3: the end flag is cleared by an accept
  assert_end_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_end);
  // R4: in block mode no error is ever recorded
  assert_block_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && !accept && !tx_err) |=> !tx_err);
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              line_in,
  input  logic              odd_par,
  input  logic              blk,
  input  logic [POS_W-1:0]  pos,
  input  logic              fresh,
  output logic              ctr_clr,
  output logic              ctr_run,
  output logic              drive_low,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr
);
  localparam logic [POS_W-1:0] P_FIRST = POS_W'(3);
  localparam logic [POS_W-1:0] P_LASTD = POS_W'(2 * DATA_W + 1);
  localparam logic [POS_W-1:0] P_PAR   = POS_W'(2 * DATA_W + 3);
  localparam logic [POS_W-1:0] P_ES    = POS_W'(2 * DATA_W + 5);
  localparam logic [POS_W-1:0] P_EE    = POS_W'(2 * DATA_W + 6);
  localparam logic [POS_W-1:0] P_DONEE = POS_W'(2 * DATA_W + 8);

  logic              active, sig;
  logic [DATA_W-1:0] shreg;
  logic              start_det, tick, bad;

  assign start_det = !active && en && !line_in;
  assign tick      = active && fresh;
  assign bad       = (par_of(16'(shreg), odd_par) != line_in);
  assign ctr_clr   = start_det;
  assign ctr_run   = active;
  assign busy      = active;
  assign drive_low = active && sig && ((pos == P_ES) || (pos == P_EE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      sig       <= 1'b0;
      shreg     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_perr  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (start_det) begin
        active <= 1'b1;
        sig    <= 1'b0;
      end else if (tick) begin
        if ((pos == POS_W'(1)) && line_in) active <= 1'b0;
        if (pos[0] && (pos >= P_FIRST) && (pos <= P_LASTD))
          shreg <= {line_in, shreg[DATA_W-1:1]};
        if (pos == P_PAR) begin
          sig       <= bad && !blk;
          out_valid <= 1'b1;
          out_data  <= shreg;
          out_perr  <= bad;
        end
        if ((pos == P_EE) && !sig) active <= 1'b0;
        if (pos == P_DONEE) active <= 1'b0;
      end
    end
  end

  // R7: a held byte stays until taken
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  // R6: an error pulse follows only a delivered parity failure
  assert_errsig_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> out_perr);
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr #(
  parameter int DATA_W = 8,
  parameter int ETU_C0 = 32,
  parameter int ETU_C1 = 64,
  parameter int ETU_C2 = 372,
  parameter int ETU_C3 = 256,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        etu_sel,
  input  logic              odd_parity,
  input  logic              gsm_mode,
  input  logic              block_mode,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              tx_end,
  output logic              tx_err,
  input  logic              io_line,
  output logic              io_drive_low
);
  localparam int ETU_M01 = (ETU_C0 > ETU_C1) ? ETU_C0 : ETU_C1;
  localparam int ETU_M23 = (ETU_C2 > ETU_C3) ? ETU_C2 : ETU_C3;
  localparam int ETU_MAX = (ETU_M01 > ETU_M23) ? ETU_M01 : ETU_M23;
  localparam int CNT_W   = $clog2(ETU_MAX / 2 + 1);
  localparam int POS_W   = $clog2(2 * (DATA_W + 2) + 7);

  logic [CNT_W-1:0]  half_cnt;
  logic [SYNC_N-1:0] sync_q;
  logic              line_s;
  logic              tx_clr, tx_run, tx_drv, tx_busy, tx_fresh;
  logic              rx_clr, rx_run, rx_drv, rx_busy, rx_fresh;
  logic [POS_W-1:0]  tx_pos, rx_pos;

  always_comb begin
    unique case (etu_sel)
      2'd0:    half_cnt = CNT_W'(ETU_C0 / 2);
      2'd1:    half_cnt = CNT_W'(ETU_C1 / 2);
      2'd2:    half_cnt = CNT_W'(ETU_C2 / 2);
      default: half_cnt = CNT_W'(ETU_C3 / 2);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_N-2:0], io_line};
  end
  assign line_s = sync_q[SYNC_N-1];

  sc_half_etu_ctr #(.CNT_W(CNT_W), .POS_W(POS_W)) i_tx_ctr (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .run(tx_run),
    .half_cnt(half_cnt), .pos(tx_pos), .fresh(tx_fresh));

  sc_half_etu_ctr #(.CNT_W(CNT_W), .POS_W(POS_W)) i_rx_ctr (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .run(rx_run),
    .half_cnt(half_cnt), .pos(rx_pos), .fresh(rx_fresh));

  sc_char_tx #(.DATA_W(DATA_W), .POS_W(POS_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(tx_valid), .in_ready(tx_ready),
    .in_data(tx_data), .odd_par(odd_parity), .gsm(gsm_mode), .blk(block_mode),
    .line_in(line_s), .rx_busy(rx_busy), .pos(tx_pos), .fresh(tx_fresh),
    .ctr_clr(tx_clr), .ctr_run(tx_run), .drive_low(tx_drv), .busy(tx_busy),
    .tx_end(tx_end), .tx_err(tx_err));

  sc_char_rx #(.DATA_W(DATA_W), .POS_W(POS_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .en(!tx_busy), .line_in(line_s),
    .odd_par(odd_parity), .blk(block_mode), .pos(rx_pos), .fresh(rx_fresh),
    .ctr_clr(rx_clr), .ctr_run(rx_run), .drive_low(rx_drv), .busy(rx_busy),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data),
    .out_perr(rx_perr));

  assign io_drive_low = tx_drv || rx_drv;

  // R10: both halves never pull the line together
  assert_one_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_drv && rx_drv));
endmodule

// File: tb/test_sc_char_xcvr.sv
module test_sc_char_xcvr;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] etu_sel;
  logic       odd_parity, gsm_mode, block_mode;
  logic       tx_valid, tx_ready, rx_valid, rx_ready, rx_perr;
  logic [7:0] tx_data, rx_data;
  logic       tx_end, tx_err, io_line, io_drive_low;
  logic       drv_m = 1'b0, drv_s = 1'b0;

  int   checks = 0, fails = 0;
  int   etu = 32;
  bit   card_listen = 1'b0;
  int   card_inject = 0;
  int   card_count = 0;
  logic [7:0] card_last = 8'h00;
  bit   card_par_ok = 1'b0;
  bit   done = 1'b0;

  assign io_line = ~(drv_m | drv_s | io_drive_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_char_xcvr i_sc_char_xcvr (
    .clk(clk), .rst_n(rst_n), .etu_sel(etu_sel), .odd_parity(odd_parity),
    .gsm_mode(gsm_mode), .block_mode(block_mode), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_perr(rx_perr),
    .tx_end(tx_end), .tx_err(tx_err), .io_line(io_line),
    .io_drive_low(io_drive_low));

  // [11:10] etu_sel, [9] odd, [8] gsm, [7:0] data
  localparam logic [11:0] VEC [8] = '{
    {2'b00, 1'b0, 1'b0, 8'h3C}, {2'b00, 1'b1, 1'b1, 8'hA7},
    {2'b01, 1'b0, 1'b1, 8'h01}, {2'b01, 1'b1, 1'b0, 8'hFE},
    {2'b10, 1'b0, 1'b0, 8'h5A}, {2'b10, 1'b1, 1'b1, 8'h80},
    {2'b11, 1'b0, 1'b1, 8'hFF}, {2'b11, 1'b1, 1'b0, 8'h00}};

  function automatic int etu_of(logic [1:0] s);
    case (s)
      2'd0: return 32;
      2'd1: return 64;
      2'd2: return 372;
      default: return 256;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model card: listens for characters and may answer with an error pulse
  initial begin
    logic [7:0] mon_d;
    logic       mon_p;
    forever begin
      @(negedge clk);
      if (card_listen && rst_n && !io_line && !drv_m && !drv_s) begin
        repeat (etu/2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          repeat (etu) @(negedge clk);
          mon_d[k] = io_line;
        end
        repeat (etu) @(negedge clk);
        mon_p = io_line;
        card_last   = mon_d;
        card_par_ok = (((^mon_d) ^ mon_p) == odd_parity);
        card_count++;
        if (card_inject > 0) begin
          card_inject--;
          repeat (etu) @(negedge clk);
          drv_m = 1'b1;
          repeat (etu) @(negedge clk);
          drv_m = 1'b0;
        end
        while (!io_line) @(negedge clk);
      end
    end
  end

  task automatic dut_send(input logic [7:0] d, output int n);
    while (!tx_ready) @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    n = 0;
    chk(tx_end == 1'b0, "R3 end cleared", int'(tx_end), 0);
    while (!tx_end && n < 30000) begin
      @(negedge clk);
      n++;
    end
    while (!tx_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic card_send(input logic [7:0] d, input bit corrupt,
                           output int lowcnt, output logic ready_mid);
    logic [9:0] fr;
    card_listen = 1'b0;
    @(negedge clk);
    fr = {(^d) ^ odd_parity ^ corrupt, d, 1'b0};
    for (int k = 0; k < 10; k++) begin
      drv_s = ~fr[k];
      if (k == 3) ready_mid = tx_ready;
      repeat (etu) @(negedge clk);
    end
    drv_s  = 1'b0;
    lowcnt = 0;
    repeat (3*etu) begin
      @(negedge clk);
      if (!io_line) lowcnt++;
    end
    card_listen = 1'b1;
  endtask

  task automatic take_rx();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R7 taken", int'(rx_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, lc, c0;
    logic rm;
    rst_n = 1'b0; etu_sel = 2'd0; odd_parity = 1'b0; gsm_mode = 1'b0;
    block_mode = 1'b0; tx_valid = 1'b0; tx_data = 8'h00; rx_ready = 1'b0;
    repeat (4) @(negedge clk);
    // R9 reset state, R10 released line
    chk(io_drive_low == 1'b0, "R10 idle release", int'(io_drive_low), 0);
    chk(tx_ready == 1'b1, "R9 tx_ready", int'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R9 rx_valid", int'(rx_valid), 0);
    chk(tx_end == 1'b0 && tx_err == 1'b0, "R9 flags", int'({tx_end, tx_err}), 0);
    rst_n = 1'b1;
    card_listen = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      etu_sel    = VEC[v][11:10];
      odd_parity = VEC[v][9];
      gsm_mode   = VEC[v][8];
      etu        = etu_of(etu_sel);
      c0         = card_count;
      dut_send(VEC[v][7:0], n);
      // R1 ETU length and R3 end point
      chk(n == (gsm_mode ? 22 : 25) * (etu/2) + 1, "R1 R3 tx_end cycle", n,
          (gsm_mode ? 22 : 25) * (etu/2) + 1);
      chk(card_last == VEC[v][7:0], "R2 data", int'(card_last), int'(VEC[v][7:0]));
      chk(card_par_ok && card_count == c0 + 1, "R2 parity", int'(card_par_ok), 1);
      card_send(VEC[v][7:0] ^ 8'hA5, 1'b0, lc, rm);
      chk(rx_valid && rx_data == (VEC[v][7:0] ^ 8'hA5), "R5 rx byte",
          int'(rx_data), int'(VEC[v][7:0] ^ 8'hA5));
      chk(rx_perr == 1'b0, "R5 good parity", int'(rx_perr), 0);
      chk(lc == 0, "R6 no pulse on good char", lc, 0);
      chk(rm == 1'b0, "R8 busy while receiving", int'(rm), 0);
      take_rx();
    end

    etu_sel = 2'd0; etu = 32; gsm_mode = 1'b0; odd_parity = 1'b0;

    // R4 retransmission after card error
    card_inject = 1; c0 = card_count;
    dut_send(8'h96, n);
    chk(n == 51 * 16 + 2, "R4 resend timing", n, 51 * 16 + 2);
    chk(tx_err == 1'b1, "R4 tx_err", int'(tx_err), 1);
    chk(card_count == c0 + 2 && card_last == 8'h96, "R4 two copies",
        card_count - c0, 2);

    // R4 block mode ignores the error pulse
    block_mode = 1'b1; card_inject = 1; c0 = card_count;
    dut_send(8'h69, n);
    chk(n == 25 * 16 + 1, "R4 block timing", n, 25 * 16 + 1);
    chk(tx_err == 1'b0, "R4 block no err", int'(tx_err), 0);
    chk(card_count == c0 + 1, "R4 block one copy", card_count - c0, 1);

    // R6 bad parity in block mode: no pulse, flag set
    card_send(8'h33, 1'b1, lc, rm);
    chk(lc == 0, "R6 block no pulse", lc, 0);
    chk(rx_valid && rx_perr && rx_data == 8'h33, "R5 perr block", int'(rx_perr), 1);
    take_rx();

    // R6 bad parity in normal mode: one ETU low
    block_mode = 1'b0;
    card_send(8'h44, 1'b1, lc, rm);
    chk(lc == 32, "R6 pulse width", lc, 32);
    chk(rx_valid && rx_perr, "R5 perr normal", int'(rx_perr), 1);
    take_rx();

    // R7 overwrite while unaccepted
    card_send(8'h11, 1'b0, lc, rm);
    card_send(8'h22, 1'b0, lc, rm);
    chk(rx_valid && rx_data == 8'h22, "R7 overwrite", int'(rx_data), 8'h22);
    take_rx();
    chk(io_drive_low == 1'b0, "R10 idle after traffic", int'(io_drive_low), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule